// File: doc/BRIEF.md
# Supervisor User-Page Access Checker

This block decides, for one access request from a paging unit, whether the access may proceed. The request carries the result of a translation that has already been found: a valid flag, plus the user/supervisor and read/write bits of every paging level that controls it. It also carries the access kind (data read, data write, instruction fetch), the current privilege level, a flag marking an implicit supervisor access, an alignment-check override flag, and two protection enables: write protection and user-page protection. The page walk, translation caching and fault delivery sit outside the block.

User-page protection stops supervisor data accesses from touching pages that user code can reach. An explicit access made at a privilege level below 3 passes this rule when the override flag is set. A fault from this rule always reports error code 1 for a read and 3 for a write. The checker also reports not-present faults and the usual user-mode rights faults, each with a 5-bit error code. Error code bit 0 is present, bit 1 is write, bit 2 is user, bit 3 is reserved-bit and bit 4 is instruction fetch.

Requests use a valid/ready handshake. The verdict is registered and appears one cycle after acceptance, together with a one-cycle result strobe. The number of paging levels is a parameter from 2 to 4. Each level uses one bit of the per-level vectors, with bit i for level i.

Top module: `upg_access_checker`

## Requirements
- R1: A page is supervisor-only when the user bit is 0 at any controlling level. It is user-accessible only when every level's user bit is 1.
- R2: A page is writable only when every level's read/write bit is 1. A single 0 at any level makes it read-only.
- R3: If the translation is not valid, the access faults with error bit 0 clear. Bit 1 is set for a data write, bit 2 is set for a user-mode access, and bit 4 is set for a fetch. User-page protection is not evaluated.
- R4: A user-mode access is one made at privilege 3 without the implicit flag. With a valid translation it faults on a supervisor-only page, or on a write to a non-writable page. The fault code sets bits 0 and 2, sets bit 1 for writes, and sets bit 4 for fetches.
- R5: When user-page protection is enabled, a supervisor data access to a user-accessible page faults in two cases: when it is implicit, or when the override flag is clear. The error code is 1 for a read and 3 for a write.
- R6: An explicit supervisor data access at privilege below 3 with the override flag set passes user-page protection. With write protection on, a write still faults with code 3 if the page is not writable.
- R7: User-page protection never affects instruction fetches, user-mode accesses, or supervisor data accesses to supervisor-only pages.
- R8: With user-page protection off, a supervisor write faults with code 3 only when write protection is on and the page is not writable. With write protection off, the write is allowed.
- R9: Error code 1 appears only for a user-page-protection fault. No other fault path produces it.
- R10: Each accepted request uses the user-page-protection enable as it stands at acceptance. Toggling the enable takes effect on the next request and needs no other action.
- R11: An accepted request gives a one-cycle result strobe on the next cycle. An allowed access reports fault 0 and error code 0.
- R12: Synchronous reset clears the result strobe, fault flag and error code. Ready is high from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Checker accepts a request |
| xlat_ok | input | 1 | Translation is valid |
| lvl_user | input | LEVELS | User bit of each paging level |
| lvl_write | input | LEVELS | Read/write bit of each paging level |
| acc_write | input | 1 | Data write (ignored for fetches) |
| acc_fetch | input | 1 | Instruction fetch |
| priv | input | 2 | Current privilege level |
| sup_implicit | input | 1 | Implicit supervisor access |
| ovr_flag | input | 1 | Alignment-check override flag |
| wp_en | input | 1 | Write-protection enable |
| upp_en | input | 1 | User-page-protection enable |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Access denied |
| rsp_code | output | 5 | Error code |

## Verification
The stimulus moves single level bits across all three levels. This shows that the supervisor-only and writable tests reduce over every level rather than over one. Supervisor data accesses are tried with each combination of override flag, implicit flag and privilege level. This separates the bypass condition from plain supervisor access. Fetches, user-mode reads and supervisor-only pages are run with protection on to show that the rule leaves them untouched. The same request is repeated while the enable toggles between requests. Read faults on every path are compared, so that code 1 can be traced to user-page protection alone.

// File: rtl/upg_pkg.sv
package upg_pkg;
   localparam int EC_WIDTH = 5;
   localparam int EC_PRES  = 0;
   localparam int EC_WR    = 1;
   localparam int EC_USER  = 2;
   localparam int EC_RSVD  = 3;
   localparam int EC_FETCH = 4;
   localparam int PRIV_W   = 2;
   localparam int MAX_LEVELS = 4;

   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_ABSENT = 2'd1,
      SRC_RIGHTS = 2'd2,
      SRC_UPP    = 2'd3
   } fault_src_e;

   typedef struct packed {
      logic                fault;
      fault_src_e          src;
      logic [EC_WIDTH-1:0] code;
   } verdict_t;
endpackage

// File: rtl/upg_level_fold.sv
module upg_level_fold #(
   parameter int LEVELS = 3
) (
   input  logic [LEVELS-1:0] us_bits,
   input  logic [LEVELS-1:0] wr_bits,
   output logic              sup_only,
   output logic              writable_all
);
   import upg_pkg::*;

   localparam int PAD = MAX_LEVELS;

   logic [PAD-1:0] us_pad;
   logic [PAD-1:0] wr_pad;

   if (LEVELS < 2 || LEVELS > PAD) begin : g_bad_levels
      $error("upg_level_fold: LEVELS must lie in 2..%0d", PAD);
   end

   for (genvar i = 0; i < PAD; i++) begin : g_lvl
      if (i < LEVELS) begin : g_used
         assign us_pad[i] = us_bits[i];
         assign wr_pad[i] = wr_bits[i];
      end else begin : g_unused
         // an absent level grants everything so it cannot restrict
         assign us_pad[i] = 1'b1;
         assign wr_pad[i] = 1'b1;
      end
   end

   assign sup_only     = ~&us_pad;   // R1
   assign writable_all = &wr_pad;    // R2
endmodule

// File: rtl/upg_rule_eval.sv
module upg_rule_eval #(
   parameter int USER_PRIV = 3
) (
   input  logic                      xlat_ok,
   input  logic                      sup_only,
   input  logic                      writable_all,
   input  logic                      acc_write,
   input  logic                      acc_fetch,
   input  logic [upg_pkg::PRIV_W-1:0] priv,
   input  logic                      sup_implicit,
   input  logic                      ovr_flag,
   input  logic                      wp_en,
   input  logic                      upp_en,
   output upg_pkg::verdict_t         verdict
);
   import upg_pkg::*;

   localparam logic [PRIV_W-1:0] UPRIV = PRIV_W'(USER_PRIV);

   logic eff_write, user_mode, upp_bypass;

   always_comb begin
      eff_write  = acc_write & ~acc_fetch;
      user_mode  = (priv == UPRIV) & ~sup_implicit;
      upp_bypass = (priv != UPRIV) & ~sup_implicit & ovr_flag;
      verdict    = '0;
      verdict.src = SRC_NONE;
      if (!xlat_ok) begin
         verdict.src            = SRC_ABSENT;          // R3
         verdict.code[EC_WR]    = eff_write;
         verdict.code[EC_USER]  = user_mode;
         verdict.code[EC_FETCH] = acc_fetch;
      end else if (user_mode) begin
         if (sup_only || (eff_write && !writable_all)) begin   // R4
            verdict.src            = SRC_RIGHTS;
            verdict.code[EC_PRES]  = 1'b1;
            verdict.code[EC_WR]    = eff_write;
            verdict.code[EC_USER]  = 1'b1;
            verdict.code[EC_FETCH] = acc_fetch;
         end
      end else if (!acc_fetch) begin
         if (upp_en && !sup_only && !upp_bypass) begin          // R5
            verdict.src           = SRC_UPP;
            verdict.code[EC_PRES] = 1'b1;
            verdict.code[EC_WR]   = eff_write;
         end else if (eff_write && wp_en && !writable_all) begin // R6 R8
            verdict.src           = SRC_RIGHTS;
            verdict.code[EC_PRES] = 1'b1;
            verdict.code[EC_WR]   = 1'b1;
         end
      end
      verdict.fault = (verdict.src != SRC_NONE);
   end

   always_comb begin
      if (acc_fetch) begin
         AST_FETCH_UNTOUCHED: assert (verdict.src != SRC_UPP);   // R7
      end
      if (sup_only) begin
         AST_SUPONLY_NO_UPP: assert (verdict.src != SRC_UPP);    // R7
      end
   end
endmodule

// File: rtl/upg_result_reg.sv
module upg_result_reg (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  upg_pkg::verdict_t verdict,
   output logic              valid_q,
   output upg_pkg::verdict_t held_q
);
   import upg_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         held_q  <= '0;
      end else begin
         valid_q <= load;
         if (load) held_q <= verdict;
      end
   end

   AST_ALLOW_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !held_q.fault) |-> (held_q.code == '0));          // R11
   AST_CODE_ONE_UPP: assert property (@(posedge clk) disable iff (rst)
      (valid_q && held_q.code == 5'd1) |-> (held_q.src == SRC_UPP)); // R9
   AST_UPP_CODE_FIXED: assert property (@(posedge clk) disable iff (rst)
      (valid_q && held_q.src == SRC_UPP) |->
      (held_q.code == 5'd1 || held_q.code == 5'd3));                 // R5
   AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (rst)
      valid_q |-> !held_q.code[EC_RSVD]);                             // R3
endmodule

// File: rtl/upg_access_checker.sv
module upg_access_checker #(
   parameter int LEVELS    = 3,
   parameter int USER_PRIV = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              xlat_ok,
   input  logic [LEVELS-1:0] lvl_user,
   input  logic [LEVELS-1:0] lvl_write,
   input  logic              acc_write,
   input  logic              acc_fetch,
   input  logic [1:0]        priv,
   input  logic              sup_implicit,
   input  logic              ovr_flag,
   input  logic              wp_en,
   input  logic              upp_en,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [4:0]        rsp_code
);
   import upg_pkg::*;

   logic     ready_q, accept, sup_only, writable_all;
   verdict_t verdict, held;

   always_ff @(posedge clk) begin
      if (rst) ready_q <= 1'b0;
      else     ready_q <= 1'b1;                           // R12
   end

   assign req_ready = ready_q;
   assign accept    = req_valid & ready_q;

   upg_level_fold #(.LEVELS(LEVELS)) u_fold (
      .us_bits      (lvl_user),
      .wr_bits      (lvl_write),
      .sup_only     (sup_only),
      .writable_all (writable_all)
   );

   upg_rule_eval #(.USER_PRIV(USER_PRIV)) u_rules (
      .xlat_ok      (xlat_ok),
      .sup_only     (sup_only),
      .writable_all (writable_all),
      .acc_write    (acc_write),
      .acc_fetch    (acc_fetch),
      .priv         (priv),
      .sup_implicit (sup_implicit),
      .ovr_flag     (ovr_flag),
      .wp_en        (wp_en),
      .upp_en       (upp_en),
      .verdict      (verdict)
   );

   upg_result_reg u_res (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .verdict (verdict),
      .valid_q (rsp_valid),
      .held_q  (held)
   );

   assign rsp_fault = held.fault;
   assign rsp_code  = held.code;

   AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
      accept |=> rsp_valid);                                  // R11
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      !accept |=> !rsp_valid);                                // R11
   AST_FAULT_MARKS_CODE: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_code != 5'd0) |-> rsp_fault);         // R11
endmodule

// File: tb/sim_upg_access_checker.sv
module sim_upg_access_checker;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 0, req_ready;
   logic       xlat_ok = 0;
   logic [2:0] lvl_user = 0, lvl_write = 0;
   logic       acc_write = 0, acc_fetch = 0;
   logic [1:0] priv = 0;
   logic       sup_implicit = 0, ovr_flag = 0, wp_en = 0, upp_en = 0;
   logic       rsp_valid, rsp_fault;
   logic [4:0] rsp_code;
   int         n_chk = 0, n_fail = 0;
   bit         done = 0;

   always #10 clk = ~clk;

   upg_access_checker #(.LEVELS(3)) u0 (.*);

   task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // issue one request and check {rsp_valid, fault, code}
   task automatic run(string tag, bit x, logic [2:0] us, logic [2:0] wr, bit w, bit f,
                      logic [1:0] p, bit imp, bit ovr, bit wp, bit up,
                      bit exp_f, logic [4:0] exp_c);
      @(negedge clk);
      xlat_ok = x; lvl_user = us; lvl_write = wr; acc_write = w; acc_fetch = f;
      priv = p; sup_implicit = imp; ovr_flag = ovr; wp_en = wp; upp_en = up;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      check(tag, {rsp_fault, rsp_code}, {exp_f, exp_c});
      check({tag, " strobe"}, {5'd0, rsp_valid}, 6'd1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R12 reset outputs", {rsp_valid, rsp_fault, rsp_code[3:0]}, 6'd0);
      rst = 0;
      @(negedge clk);
      check("R12 ready", {5'd0, req_ready}, 6'd1);
      check("R12 no strobe", {5'd0, rsp_valid}, 6'd0);
   endtask

   task automatic t_not_present;
      run("R3 sup read absent", 0, 3'b111, 3'b111, 0, 0, 0, 0, 0, 1, 1, 1, 5'd0);
      run("R3 user write absent", 0, 3'b111, 3'b111, 1, 0, 3, 0, 0, 1, 1, 1, 5'd6);
      run("R3 user fetch absent", 0, 3'b000, 3'b000, 0, 1, 3, 0, 0, 1, 1, 1, 5'd20);
   endtask

   task automatic t_user_mode;
      run("R1 R4 user read suponly lvl1", 1, 3'b101, 3'b111, 0, 0, 3, 0, 0, 1, 1, 1, 5'd5);
      run("R1 R4 user read suponly lvl2", 1, 3'b011, 3'b111, 0, 0, 3, 0, 0, 1, 0, 1, 5'd5);
      run("R2 R4 user write ro lvl0", 1, 3'b111, 3'b110, 1, 0, 3, 0, 0, 1, 1, 1, 5'd7);
      run("R4 user read user page", 1, 3'b111, 3'b000, 0, 0, 3, 0, 0, 1, 1, 0, 5'd0);
      run("R4 user fetch suponly", 1, 3'b110, 3'b111, 0, 1, 3, 0, 0, 1, 1, 1, 5'd21);
   endtask

   task automatic t_upp_block;
      run("R5 sup read user page", 1, 3'b111, 3'b111, 0, 0, 0, 0, 0, 1, 1, 1, 5'd1);
      run("R5 sup write user page", 1, 3'b111, 3'b111, 1, 0, 0, 0, 0, 1, 1, 1, 5'd3);
      run("R5 implicit with override", 1, 3'b111, 3'b111, 0, 0, 3, 1, 1, 1, 1, 1, 5'd1);
      run("R5 implicit priv0 override", 1, 3'b111, 3'b111, 0, 0, 0, 1, 1, 1, 1, 1, 5'd1);
   endtask

   task automatic t_override;
      run("R6 override read", 1, 3'b111, 3'b111, 0, 0, 0, 0, 1, 1, 1, 0, 5'd0);
      run("R6 override write writable", 1, 3'b111, 3'b111, 1, 0, 2, 0, 1, 1, 1, 0, 5'd0);
      run("R6 override write ro lvl2", 1, 3'b111, 3'b011, 1, 0, 1, 0, 1, 1, 1, 1, 5'd3);
   endtask

   task automatic t_no_effect;
      run("R7 sup fetch user page", 1, 3'b111, 3'b111, 0, 1, 0, 0, 0, 1, 1, 0, 5'd0);
      run("R7 sup read suponly", 1, 3'b011, 3'b000, 0, 0, 0, 0, 0, 1, 1, 0, 5'd0);
      run("R7 sup write suponly", 1, 3'b110, 3'b111, 1, 0, 0, 0, 0, 1, 1, 0, 5'd0);
   endtask

   task automatic t_wp;
      run("R8 wp on ro write", 1, 3'b010, 3'b101, 1, 0, 0, 0, 0, 1, 0, 1, 5'd3);
      run("R8 wp off ro write", 1, 3'b010, 3'b101, 1, 0, 0, 0, 0, 0, 0, 0, 5'd0);
      run("R8 upp off user page read", 1, 3'b111, 3'b000, 0, 0, 0, 0, 0, 1, 0, 0, 5'd0);
   endtask

   task automatic t_code_one;
      run("R9 user rights read not 1", 1, 3'b001, 3'b111, 0, 0, 3, 0, 0, 1, 1, 1, 5'd5);
      run("R9 absent sup read not 1", 0, 3'b111, 3'b111, 0, 0, 1, 0, 0, 1, 1, 1, 5'd0);
   endtask

   task automatic t_toggle;
      run("R10 enable on", 1, 3'b111, 3'b111, 0, 0, 0, 0, 0, 1, 1, 1, 5'd1);
      run("R10 enable off", 1, 3'b111, 3'b111, 0, 0, 0, 0, 0, 1, 0, 0, 5'd0);
      run("R10 enable on again", 1, 3'b111, 3'b111, 0, 0, 0, 0, 0, 1, 1, 1, 5'd1);
   endtask

   task automatic t_strobe;
      @(negedge clk);
      check("R11 strobe one cycle", {5'd0, rsp_valid}, 6'd0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_not_present();
      t_user_mode();
      t_upp_block();
      t_override();
      t_no_effect();
      t_wp();
      t_code_one();
      t_toggle();
      t_strobe();
      finish_run();
   end
endmodule